// File: doc/BRIEF.md
# Bus Trigger Arming Controller

This block decides when a trigger sent over the instrument bus may move the output setpoints, and performs that move. Software first loads a pending voltage and a pending current. The block is then armed, either once by an arm pulse or continuously by a latched continuous-mode flag. While armed it shows a waiting-for-trigger status bit. A qualified bus trigger copies the pending values into the active setpoints and produces a one-cycle completion pulse.

A trigger counts only when four things hold together: the block is armed, the trigger source selection is the bus, the output is enabled, and the device is addressed as a listener. A trigger that fails any of these is dropped without side effect and raises no error. In one-shot mode an accepted trigger disarms the block. In continuous mode the block stays armed. An abort pulse disarms the block in every mode. If continuous mode is still on, the block re-arms on the following cycle.

Top module: `btac_top`

## Requirements
- R1: After a synchronous reset the waiting flag is 0, both active setpoints are 0 and the completion pulse is 0.
- R2: With continuous mode off, an arm pulse on an unarmed block sets the waiting flag on the next clock edge.
- R3: A trigger is accepted when the waiting flag is 1, source-is-bus is 1, output-enabled is 1, listener-addressed is 1 and no abort is present. At the next edge the active voltage and current take the pending values sampled with the trigger, and the completion pulse is 1 for that one cycle.
- R4: With continuous mode off, an accepted trigger clears the waiting flag at the same edge. A later trigger leaves the setpoints unchanged and gives no completion pulse.
- R5: A trigger arriving while the waiting flag is 0 is dropped: no pulse and no setpoint change.
- R6: A trigger is also dropped, with the waiting flag left at 1, when the output is disabled, when the device is not addressed as a listener, or when the source selection is not the bus.
- R7: With continuous mode on, an unarmed block arms itself at the next edge without any arm pulse, and stays armed after every accepted trigger.
- R8: An abort pulse clears the waiting flag at the next edge and takes priority over a trigger in the same cycle, which is then dropped. If continuous mode is on, the flag returns to 1 one edge later.
- R9: The status fragment output carries the waiting flag at bit position 5 and zero in every other bit.
- R10: The active setpoints change only at the edge that follows an accepted trigger.
- R11: An arm pulse in the same cycle as an accepted trigger, with continuous mode off, does not re-arm the block: the waiting flag is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_pulse | input | 1 | Single-shot arm request |
| abort_pulse | input | 1 | Disarm request |
| bus_trig_pulse | input | 1 | Trigger received over the bus |
| cont_mode | input | 1 | Continuous re-arm enable (level) |
| src_is_bus | input | 1 | Trigger source selection is the bus |
| out_enabled | input | 1 | Output stage is on |
| listener_sel | input | 1 | Device is addressed as a listener |
| pend_volt | input | 16 | Pending voltage setpoint |
| pend_curr | input | 16 | Pending current setpoint |
| act_volt | output | 16 | Active voltage setpoint |
| act_curr | output | 16 | Active current setpoint |
| waiting | output | 1 | Waiting-for-trigger flag |
| stat_frag | output | 8 | Operation-condition fragment, waiting flag at bit 5 |
| trig_done | output | 1 | One-cycle pulse after an accepted trigger |

## Verification
The bench builds the block with its defaults: 16-bit setpoints, an 8-bit status fragment and the waiting flag at bit 5. This width lets pending values such as all ones, alternating patterns and single high bits show that every setpoint bit loads. The 8-bit fragment shows that only bit 5 is ever driven. Each disqualifying input is dropped on its own against an armed block. This exposes a qualifier that ignores any one of the four conditions. Same-cycle collisions of abort, arm and trigger fix the priority order.

// File: rtl/btac_pkg.sv
package btac_pkg;

    localparam int SP_W     = 16;
    localparam int STAT_W   = 8;
    localparam int WTG_POS  = 5;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic arm;
        logic abort;
        logic trig;
        logic cont;
    } arm_req_t;

    typedef struct packed {
        logic src_bus;
        logic out_on;
        logic listen;
    } trig_gate_t;

    function automatic logic gate_open(input trig_gate_t g);
        return g.src_bus & g.out_on & g.listen;
    endfunction

    function automatic logic [STAT_W-1:0] place_bit(input logic b, input int pos);
        logic [STAT_W-1:0] v;
        v = '0;
        v[pos] = b;
        return v;
    endfunction

endpackage

// File: rtl/btac_qualify.sv
module btac_qualify
    import btac_pkg::*;
(
    input  logic       waiting_i,
    input  arm_req_t   req_i,
    input  trig_gate_t gate_i,
    output logic       accept_o
);
    // Abort wins over a trigger arriving in the same cycle.
    always_comb begin
        accept_o = req_i.trig & waiting_i & gate_open(gate_i) & ~req_i.abort;
    end
endmodule

// File: rtl/btac_arm_fsm.sv
module btac_arm_fsm
    import btac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arm_req_t req_i,
    input  logic     accept_i,
    output logic     waiting_o
);
    arm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (req_i.abort) begin
            state_d = ARM_IDLE;
        end else if (accept_i) begin
            state_d = req_i.cont ? ARM_WAIT : ARM_IDLE;
        end else if (state_q == ARM_IDLE && (req_i.arm || req_i.cont)) begin
            state_d = ARM_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARM_IDLE;
        else     state_q <= state_d;
    end

    assign waiting_o = (state_q == ARM_WAIT);
endmodule

// File: rtl/btac_setpoints.sv
module btac_setpoints #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] volt_i,
    input  logic [W-1:0] curr_i,
    output logic [W-1:0] volt_o,
    output logic [W-1:0] curr_o,
    output logic         done_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            volt_o <= '0;
            curr_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= load_i;
            if (load_i) begin
                volt_o <= volt_i;
                curr_o <= curr_i;
            end
        end
    end
endmodule

// File: rtl/btac_top.sv
module btac_top
    import btac_pkg::*;
#(
    parameter int SPW   = SP_W,
    parameter int SW    = STAT_W,
    parameter int WPOS  = WTG_POS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm_pulse,
    input  logic           abort_pulse,
    input  logic           bus_trig_pulse,
    input  logic           cont_mode,
    input  logic           src_is_bus,
    input  logic           out_enabled,
    input  logic           listener_sel,
    input  logic [SPW-1:0] pend_volt,
    input  logic [SPW-1:0] pend_curr,
    output logic [SPW-1:0] act_volt,
    output logic [SPW-1:0] act_curr,
    output logic           waiting,
    output logic [SW-1:0]  stat_frag,
    output logic           trig_done
);
    arm_req_t   req;
    trig_gate_t gate;
    logic       accept;

    assign req  = '{arm: arm_pulse, abort: abort_pulse, trig: bus_trig_pulse, cont: cont_mode};
    assign gate = '{src_bus: src_is_bus, out_on: out_enabled, listen: listener_sel};

    btac_qualify u_qual (
        .waiting_i (waiting),
        .req_i     (req),
        .gate_i    (gate),
        .accept_o  (accept)
    );

    btac_arm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .accept_i  (accept),
        .waiting_o (waiting)
    );

    btac_setpoints #(.W(SPW)) u_sp (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .volt_i (pend_volt),
        .curr_i (pend_curr),
        .volt_o (act_volt),
        .curr_o (act_curr),
        .done_o (trig_done)
    );

    genvar gi;
    generate
        for (gi = 0; gi < SW; gi++) begin : g_stat
            if (gi == WPOS) begin : g_w
                assign stat_frag[gi] = waiting;
            end else begin : g_z
                assign stat_frag[gi] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/btac_chk.sv
module btac_chk #(
    parameter int SPW  = 16,
    parameter int SW   = 8,
    parameter int WPOS = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           arm_pulse,
    input logic           abort_pulse,
    input logic           bus_trig_pulse,
    input logic           cont_mode,
    input logic           src_is_bus,
    input logic           out_enabled,
    input logic           listener_sel,
    input logic [SPW-1:0] pend_volt,
    input logic [SPW-1:0] pend_curr,
    input logic [SPW-1:0] act_volt,
    input logic [SPW-1:0] act_curr,
    input logic           waiting,
    input logic [SW-1:0]  stat_frag,
    input logic           trig_done
);
    logic ok_trig;
    assign ok_trig = bus_trig_pulse & waiting & src_is_bus & out_enabled
                   & listener_sel & ~abort_pulse;

    p_load_volt_r3: assert property (@(posedge clk) disable iff (rst)
        ok_trig |=> (act_volt == $past(pend_volt) && act_curr == $past(pend_curr) && trig_done));

    p_one_shot_r4: assert property (@(posedge clk) disable iff (rst)
        (ok_trig && !cont_mode) |=> !waiting);

    p_drop_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_trig_pulse && !waiting) |=> !trig_done);

    p_gate_closed_r6: assert property (@(posedge clk) disable iff (rst)
        (waiting && !abort_pulse && !(src_is_bus && out_enabled && listener_sel)) |=> waiting);

    p_cont_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (cont_mode && !abort_pulse) |=> waiting);

    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> (!waiting && !trig_done));

    p_hold_sp_r10: assert property (@(posedge clk) disable iff (rst)
        !ok_trig |=> ($stable(act_volt) && $stable(act_curr) && !trig_done));

    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (arm_pulse && !abort_pulse && !waiting) |=> waiting);

    always_comb begin
        if (!rst) begin
            p_stat_bit_r9: assert (stat_frag == (SW'(waiting) << WPOS));
        end
    end
endmodule

bind btac_top btac_chk #(.SPW(SPW), .SW(SW), .WPOS(WPOS)) u_chk (.*);

// File: tb/sim_btac_top.sv
module sim_btac_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        arm_pulse, abort_pulse, bus_trig_pulse;
    logic        cont_mode, src_is_bus, out_enabled, listener_sel;
    logic [15:0] pend_volt, pend_curr, act_volt, act_curr;
    logic        waiting, trig_done;
    logic [7:0]  stat_frag;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    btac_top u0 (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_arm();   arm_pulse = 1;      cyc(); arm_pulse = 0;      endtask
    task automatic pulse_abort(); abort_pulse = 1;    cyc(); abort_pulse = 0;    endtask
    task automatic pulse_trig();  bus_trig_pulse = 1; cyc(); bus_trig_pulse = 0; endtask

    task automatic do_reset();
        rst = 1; arm_pulse = 0; abort_pulse = 0; bus_trig_pulse = 0;
        cont_mode = 0; src_is_bus = 1; out_enabled = 1; listener_sel = 1;
        pend_volt = 16'h1234; pend_curr = 16'h5678;
        cyc(); cyc(); rst = 0; cyc();
    endtask

    task automatic t_reset();
        do_reset();
        chk(waiting == 0, "R1 waiting", waiting, 0);
        chk(act_volt == 0 && act_curr == 0, "R1 setpoints", {act_volt, act_curr}, 0);
        chk(trig_done == 0, "R1 done", trig_done, 0);
        chk(stat_frag == 0, "R9 frag idle", stat_frag, 0);
    endtask

    task automatic t_unarmed();
        do_reset();
        pulse_trig();
        chk(trig_done == 0, "R5 no pulse", trig_done, 0);
        chk(act_volt == 0, "R5 no load", act_volt, 0);
    endtask

    task automatic t_one_shot();
        do_reset();
        pulse_arm();
        chk(waiting == 1, "R2 armed", waiting, 1);
        chk(stat_frag == 8'h20, "R9 frag armed", stat_frag, 8'h20);
        pend_volt = 16'hFFFF; pend_curr = 16'hA5A5;
        pulse_trig();
        pend_volt = 16'h0001; pend_curr = 16'h0002;
        chk(act_volt == 16'hFFFF, "R3 volt", act_volt, 16'hFFFF);
        chk(act_curr == 16'hA5A5, "R3 curr", act_curr, 16'hA5A5);
        chk(trig_done == 1, "R3 pulse", trig_done, 1);
        chk(waiting == 0, "R4 disarmed", waiting, 0);
        cyc();
        chk(trig_done == 0, "R3 pulse width", trig_done, 0);
        chk(act_volt == 16'hFFFF, "R10 held", act_volt, 16'hFFFF);
        pulse_trig();
        chk(trig_done == 0 && act_curr == 16'hA5A5, "R4 second trig", act_curr, 16'hA5A5);
    endtask

    task automatic t_gate(input int which);
        do_reset();
        pulse_arm();
        pend_volt = 16'h8001;
        if (which == 0) out_enabled = 0;
        if (which == 1) listener_sel = 0;
        if (which == 2) src_is_bus = 0;
        pulse_trig();
        chk(trig_done == 0, "R6 no pulse", trig_done, 0);
        chk(act_volt == 0, "R10 no load", act_volt, 0);
        chk(waiting == 1, "R6 still waiting", waiting, 1);
        out_enabled = 1; listener_sel = 1; src_is_bus = 1;
        pulse_trig();
        chk(act_volt == 16'h8001, "R3 load after gate", act_volt, 16'h8001);
    endtask

    task automatic t_cont();
        do_reset();
        cont_mode = 1;
        cyc();
        chk(waiting == 1, "R7 self arm", waiting, 1);
        pend_volt = 16'h5555; pend_curr = 16'h0F0F;
        bus_trig_pulse = 1; cyc();
        chk(trig_done == 1 && act_volt == 16'h5555, "R7 first", act_volt, 16'h5555);
        chk(waiting == 1, "R7 rearmed", waiting, 1);
        pend_volt = 16'hAAAA; cyc(); bus_trig_pulse = 0;
        chk(trig_done == 1 && act_volt == 16'hAAAA, "R7 back to back", act_volt, 16'hAAAA);
        cont_mode = 0;
    endtask

    task automatic t_abort();
        do_reset();
        cont_mode = 1; cyc();
        pend_volt = 16'h7777;
        abort_pulse = 1; bus_trig_pulse = 1; cyc();
        abort_pulse = 0; bus_trig_pulse = 0;
        chk(waiting == 0, "R8 cleared", waiting, 0);
        chk(trig_done == 0 && act_volt == 0, "R8 trig dropped", act_volt, 0);
        cyc();
        chk(waiting == 1, "R8 cont rearm", waiting, 1);
        cont_mode = 0;
        pulse_abort();
        cyc();
        chk(waiting == 0, "R8 stays idle", waiting, 0);
    endtask

    task automatic t_arm_collide();
        do_reset();
        pulse_arm();
        pend_volt = 16'h0400;
        arm_pulse = 1; bus_trig_pulse = 1; cyc();
        arm_pulse = 0; bus_trig_pulse = 0;
        chk(act_volt == 16'h0400, "R11 accepted", act_volt, 16'h0400);
        chk(waiting == 0, "R11 not rearmed", waiting, 0);
    endtask

    initial begin
        t_reset();
        t_unarmed();
        t_one_shot();
        for (int g = 0; g < 3; g++) t_gate(g);
        t_cont();
        t_abort();
        t_arm_collide();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule